// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block chooses the data direction of one memory channel: read mode or write mode. Each cycle it looks at how many entries sit in the read queue and the write queue, and how many bursts of each kind have gone out since the last change of direction. From these it forms the direction wanted for the next cycle and registers it as the current direction. The issue logic around it uses the current direction to decide which queue to serve.

Writes are held back until the write queue fills to a high watermark. They are then drained until the queue falls below a low watermark, so the channel does not turn around on every write. Both watermarks are fractions of the write queue depth, and a direction must issue a set number of bursts before it gives way by choice. An empty read queue hands the channel to pending writes at once. A drain request keeps the channel writing until the write queue is empty.

The issued-burst input is a plain event: `issue_vld` high for one cycle means one burst went out, and its type is given by `issue_is_wr`. The block never pushes back. All other pins are plain levels.

Top module: `rw_turn_arbiter`

## Requirements
- R1: After reset the current direction is read (`dir_cur`=0, where 0 = read and 1 = write), `turn_pulse` is 0, and with both queues empty `dir_next` is 0.
- R2: The high watermark is floor(WQ_DEPTH*HI_PCT/100) and the low watermark is floor(WQ_DEPTH*LO_PCT/100). With the default values (32 entries, 85 %, 50 %) they are 27 and 16. `cfg_err` is 1 exactly when LO_PCT is not strictly below HI_PCT.
- R3: In read mode, an empty read queue with at least one write pending gives `dir_next`=1.
- R4: In read mode, with no drain request and reads waiting, `dir_next` becomes 1 only when at least MIN_RD reads have issued in this turn and write occupancy is at or above the high watermark.
- R5: In write mode, without a drain request, `dir_next` returns to 0 when three things hold: write occupancy is below the low watermark, at least MIN_WR writes have issued in this turn, and the read queue is not empty. Otherwise, while writes are pending, it stays at 1.
- R6: In write mode, an empty write queue gives `dir_next`=0.
- R7: While `drain_req` is 1 and writes are pending, `dir_next` is 1 in both modes, even when the minimum read count has not been reached.
- R8: The per-turn read and write burst counts are cleared on the clock edge where the direction changes, so a new turn starts from zero issued bursts.
- R9: `dir_cur` takes the value of `dir_next` on each rising clock edge. `turn_pulse` is 1 for exactly the one cycle in which `dir_cur` holds a newly changed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_occ | input | $clog2(RQ_DEPTH+1) | Entries waiting in the read queue |
| wr_occ | input | $clog2(WQ_DEPTH+1) | Entries waiting in the write queue |
| issue_vld | input | 1 | One burst issued this cycle |
| issue_is_wr | input | 1 | Type of the issued burst: 1 = write, 0 = read |
| drain_req | input | 1 | Empty the write queue before anything else |
| dir_cur | output | 1 | Registered bus direction: 0 = read, 1 = write |
| dir_next | output | 1 | Direction to be taken at the next clock edge |
| turn_pulse | output | 1 | One-cycle pulse when `dir_cur` has just changed |
| cfg_err | output | 1 | Watermark percentages are inconsistent |

## Verification
`dir_next` is combinational, so the bench checks it in the same cycle the occupancy or drain inputs change, after a short settle delay away from the clock edge. `dir_cur` and `turn_pulse` are due one rising edge after `dir_next` changes, and the bench checks them just after that edge. A burst pulse is counted at the edge that samples it, so it first affects `dir_next` in the following cycle, and the bench releases the pulse before it checks. The watermark boundaries at 26/27 and 16/15 are each checked on both sides.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;
  localparam logic DIR_RD = 1'b0;
  localparam logic DIR_WR = 1'b1;

  // Watermark level from a buffer depth and a percentage (integer floor).
  function automatic int wm_level(input int depth, input int pct);
    return (depth * pct) / 100;
  endfunction
endpackage

// File: rtl/turn_counter.sv
module turn_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic met_o
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // Saturates at LIMIT: only "reached the minimum" matters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != LIM_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign met_o = (cnt_q >= LIM_V);

  // R8: a direction change starts the new turn at zero bursts
  p_clear_on_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_V);
endmodule

// File: rtl/turn_decider.sv
module turn_decider #(
  parameter int RW     = 6,
  parameter int WW     = 6,
  parameter int HI_LVL = 27,
  parameter int LO_LVL = 16
) (
  input  logic          dir_q,
  input  logic [RW-1:0] rd_occ,
  input  logic [WW-1:0] wr_occ,
  input  logic          rd_met,
  input  logic          wr_met,
  input  logic          drain,
  output logic          dir_nxt
);
  import rw_turn_pkg::*;

  localparam logic [WW-1:0] HI_V = WW'(HI_LVL);
  localparam logic [WW-1:0] LO_V = WW'(LO_LVL);

  logic rd_empty, wr_empty, at_high, below_low;

  assign rd_empty  = (rd_occ == '0);
  assign wr_empty  = (wr_occ == '0);
  assign at_high   = (wr_occ >= HI_V);
  assign below_low = (wr_occ < LO_V);

  always_comb begin
    dir_nxt = dir_q;
    if (dir_q == DIR_RD) begin
      if (!wr_empty && (rd_empty || drain || (rd_met && at_high)))
        dir_nxt = DIR_WR;
    end else begin
      if (wr_empty)
        dir_nxt = DIR_RD;
      else if (!drain && below_low && wr_met && !rd_empty)
        dir_nxt = DIR_RD;
    end
  end
endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter #(
  parameter int RQ_DEPTH = 32,
  parameter int WQ_DEPTH = 32,
  parameter int HI_PCT   = 85,
  parameter int LO_PCT   = 50,
  parameter int MIN_RD   = 4,
  parameter int MIN_WR   = 4,
  localparam int RW = $clog2(RQ_DEPTH + 1),
  localparam int WW = $clog2(WQ_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rd_occ,
  input  logic [WW-1:0] wr_occ,
  input  logic          issue_vld,
  input  logic          issue_is_wr,
  input  logic          drain_req,
  output logic          dir_cur,
  output logic          dir_next,
  output logic          turn_pulse,
  output logic          cfg_err
);
  import rw_turn_pkg::*;

  localparam int HI_LVL = wm_level(WQ_DEPTH, HI_PCT);
  localparam int LO_LVL = wm_level(WQ_DEPTH, LO_PCT);
  localparam logic [WW-1:0] HI_V = WW'(HI_LVL);

  logic       dir_q, turn_q, switch_now;
  logic [1:0] met;   // [0] reads reached minimum, [1] writes reached minimum

  assign cfg_err = (LO_PCT >= HI_PCT);

  turn_decider #(
    .RW(RW), .WW(WW), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)
  ) u_decide (
    .dir_q  (dir_q),
    .rd_occ (rd_occ),
    .wr_occ (wr_occ),
    .rd_met (met[0]),
    .wr_met (met[1]),
    .drain  (drain_req),
    .dir_nxt(dir_next)
  );

  assign switch_now = (dir_next != dir_q);

  for (genvar g = 0; g < 2; g++) begin : g_turn_cnt
    localparam int LIM = (g == 0) ? MIN_RD : MIN_WR;
    turn_counter #(.LIMIT(LIM)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr_i(switch_now),
      .inc_i(issue_vld && (issue_is_wr == 1'(g))),
      .met_o(met[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_RD;
      turn_q <= 1'b0;
    end else begin
      dir_q  <= dir_next;
      turn_q <= switch_now;
    end
  end

  assign dir_cur    = dir_q;
  assign turn_pulse = turn_q;

  // R9: pulse and direction change coincide
  p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    turn_pulse |-> (dir_cur != $past(dir_cur)));
  p_change_has_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_cur != $past(dir_cur)) |-> turn_pulse);

  // R3: starved reads hand the channel to writes
  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_cur && (rd_occ == '0) && (wr_occ != '0)) |=> dir_cur);

  // R4: no voluntary write turn below the high watermark
  p_no_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_cur && !drain_req && (rd_occ != '0) && (wr_occ < HI_V)) |=> !dir_cur);

  // R6: nothing left to write returns the channel to reads
  p_write_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_cur && (wr_occ == '0)) |=> !dir_cur);

  // R7: draining holds write mode while writes remain
  p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_cur && drain_req && (wr_occ != '0)) |=> dir_cur);
endmodule

// File: tb/rw_turn_arbiter_test.sv
module rw_turn_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rd_occ = '0;
  logic [5:0] wr_occ = '0;
  logic       issue_vld = 1'b0;
  logic       issue_is_wr = 1'b0;
  logic       drain_req = 1'b0;
  logic       dir_cur, dir_next, turn_pulse, cfg_err;
  logic       b_cur, b_next, b_pulse, b_err;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rw_turn_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .issue_vld(issue_vld), .issue_is_wr(issue_is_wr), .drain_req(drain_req),
    .dir_cur(dir_cur), .dir_next(dir_next), .turn_pulse(turn_pulse),
    .cfg_err(cfg_err)
  );

  rw_turn_arbiter #(.HI_PCT(40), .LO_PCT(40)) uut_bad (
    .clk(clk), .rst_n(rst_n), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .issue_vld(issue_vld), .issue_is_wr(issue_is_wr), .drain_req(drain_req),
    .dir_cur(b_cur), .dir_next(b_next), .turn_pulse(b_pulse),
    .cfg_err(b_err)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Advance one edge; leave time 1 unit after it.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic issue(input logic is_wr, input int n);
    for (int i = 0; i < n; i++) begin
      issue_vld = 1'b1;
      issue_is_wr = is_wr;
      step();
    end
    issue_vld = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R1", "dir_cur after reset", dir_cur, 1'b0);
    chk("R1", "dir_next idle", dir_next, 1'b0);
    chk("R1", "turn_pulse after reset", turn_pulse, 1'b0);
    chk("R2", "cfg_err default", cfg_err, 1'b0);
    chk("R2", "cfg_err equal pct", b_err, 1'b1);
  endtask

  task automatic t_empty_read();
    rd_occ = 0; wr_occ = 1; settle();
    chk("R3", "dir_next empty reads", dir_next, 1'b1);
    step();
    chk("R9", "dir_cur follows", dir_cur, 1'b1);
    chk("R9", "pulse on change", turn_pulse, 1'b1);
    step();
    chk("R9", "pulse one cycle", turn_pulse, 1'b0);
    chk("R5", "stay write no reads", dir_cur, 1'b1);
    wr_occ = 0; settle();
    chk("R6", "dir_next write empty", dir_next, 1'b0);
    step();
    chk("R6", "back to read", dir_cur, 1'b0);
    step();
  endtask

  task automatic t_high_mark();
    rd_occ = 5; wr_occ = 27; settle();
    chk("R4", "at high, no reads yet", dir_next, 1'b0);
    wr_occ = 26;
    issue(1'b0, 4);
    chk("R2", "26 below high mark", dir_next, 1'b0);
    wr_occ = 27; settle();
    chk("R4", "at high after min reads", dir_next, 1'b1);
    step();
    chk("R4", "write mode entered", dir_cur, 1'b1);
  endtask

  task automatic t_low_mark();
    rd_occ = 5; wr_occ = 15; settle();
    chk("R5", "below low, no writes yet", dir_next, 1'b1);
    issue(1'b1, 3);
    chk("R5", "three writes short", dir_next, 1'b1);
    wr_occ = 16;
    issue(1'b1, 1);
    chk("R2", "16 not below low mark", dir_next, 1'b1);
    wr_occ = 15; rd_occ = 0; settle();
    chk("R5", "no reads waiting", dir_next, 1'b1);
    rd_occ = 5; settle();
    chk("R5", "return to reads", dir_next, 1'b0);
    step();
    chk("R5", "read mode entered", dir_cur, 1'b0);
  endtask

  task automatic t_clear();
    rd_occ = 5; wr_occ = 27; settle();
    chk("R8", "read count restarted", dir_next, 1'b0);
    rd_occ = 0; wr_occ = 10; step();
    chk("R3", "forced write turn", dir_cur, 1'b1);
    rd_occ = 5; settle();
    chk("R8", "write count restarted", dir_next, 1'b1);
    wr_occ = 0; step();
    chk("R6", "read after empty", dir_cur, 1'b0);
    step();
  endtask

  task automatic t_drain();
    rd_occ = 5; wr_occ = 3; drain_req = 1'b1; settle();
    chk("R7", "drain forces write", dir_next, 1'b1);
    step();
    chk("R7", "write mode on drain", dir_cur, 1'b1);
    wr_occ = 2;
    issue(1'b1, 4);
    chk("R7", "drain holds write", dir_next, 1'b1);
    chk("R7", "still writing", dir_cur, 1'b1);
    wr_occ = 0; settle();
    chk("R7", "drain done", dir_next, 1'b0);
    step();
    chk("R6", "read after drain", dir_cur, 1'b0);
    drain_req = 1'b0; rd_occ = 0;
    step();
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty_read();
    t_high_mark();
    t_low_mark();
    t_clear();
    t_drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule